// File: doc/BRIEF.md
# Clock Generator Serial Control Slave

This block is the control plane of a four-output clock generator. It sits on a two-wire SMBus as a slave and holds a three-byte control space. Through that space a host selects the output frequency ratio, enables each output, and sets two test bits. A fixed identity byte can also be read back. The device address is five fixed bits followed by two strap pins, so up to four generators can share one bus.

Every transfer is indexed and counted. A write carries a start index, a byte count and then the data bytes. A read first sets the index with a short write. After a repeated start the slave returns the count byte, followed by register contents from that index onward. The host acknowledges each byte it wants to keep receiving.

The register bits drive the analog side. A hardware output-enable pin combines with a per-output bit to give an enable and a high-impedance control for each output. A mode pin chooses between the PLL clock and the bypassed reference clock. The block's own logic runs on a fast system clock that oversamples both bus lines.

Top module: `clkgen_smb_ctrl`

## Requirements
- R1: After reset, control byte 0 holds 0x1F (ratio code 1 = ×4/1, all four enables set), control byte 1 holds 0x00, the stored byte count is 3 and `sda_oe` is low.
- R2: Only the address byte {5'b11011, strap_a[1], strap_a[0], rw} is acknowledged. Here rw=0 means write and rw=1 means read. A transfer to any other address gets no acknowledge and changes no register.
- R3: A block write (address with rw=0, index N, count X, then data bytes) acknowledges every byte. It stores data byte k into index N+k. Index 0 maps as follows: bit 7 goes to test bit `vendor_test[1]`, bits 6:4 to the ratio code, and bits 3:0 to the output enables. Index 1 bit 0 goes to `vendor_test[0]`.
- R4: Data bytes beyond the count X of a block write get no acknowledge and are discarded.
- R5: A block read (address with rw=0, index N, repeated start, address with rw=1) returns the count from the most recent block write first. It then returns the bytes at index N, N+1, ..., advancing on each host acknowledge, and stops driving after a host not-acknowledge.
- R6: Index 2 reads {REV_ID, 3'b001}, which is 0x09 with default parameters, and ignores writes. Indices 3 and above read 0x00. Writes to them are acknowledged and discarded.
- R7: Ratio codes 0 to 7 decode to numerator/denominator 3/1, 4/1, 5/1, 6/1, 8/1, 9/2, 15/2 and 15/4.
- R8: `out_en[i]` is high only when `oe_pin` is high and enable bit i is 1. `out_hiz[i]` is always its complement.
- R9: `sel_pll` follows `bypass_n`: low selects the reference clock, high selects the PLL clock.
- R10: A stop condition in the middle of a block write ends the transfer. Bytes already acknowledged stay stored, and the next transfer works normally.
- R11: SDA is only ever pulled low (`sda_oe` high) and never driven high. It changes only while SCL is low, except when released at a start or stop.
- R12: Writing a register with its current value causes no change on any control output.
- R13: A pulse on SDA lasting two system clocks or less while SCL is high is not taken as a start or stop condition.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst | input | 1 | Synchronous active-high reset |
| scl_in | input | 1 | Bus clock line level |
| sda_in | input | 1 | Bus data line level |
| sda_oe | output | 1 | Pull data line low when high |
| strap_a | input | 2 | Address strap pins, low two address bits |
| oe_pin | input | 1 | Hardware output enable, active high |
| bypass_n | input | 1 | Mode pin, 0 = reference bypass, 1 = PLL |
| out_en | output | 4 | Per-output switching enable |
| out_hiz | output | 4 | Per-output high-impedance control |
| sel_pll | output | 1 | Output source select, 1 = PLL clock |
| mult_code | output | 3 | Ratio code from control byte 0 |
| mult_num | output | 4 | Decoded ratio numerator |
| mult_den | output | 3 | Decoded ratio denominator |
| vendor_test | output | 2 | Test bits: [1] from byte 0 bit 7, [0] from byte 1 bit 0 |

## Verification
A wrong protocol state shows up at the port within one bus bit time. It appears as a missing or extra low pulse on `sda_oe` during an acknowledge slot, or as wrong read-back bits, and the bench samples both at the bus clock high phase. A corrupted index or count pointer gives a write to the wrong register. That becomes visible on `mult_code`, `out_en` or `vendor_test` a few system clocks after the acknowledging SCL fall. Read-back also exposes such errors, because the count byte and data order are fully determined by the last write. Line filter faults show up as acknowledges lost after a short SDA glitch.

// File: rtl/clkctl_pkg.sv
package clkctl_pkg;

    localparam logic [4:0] ADDR_BASE  = 5'b11011;
    localparam logic [2:0] VENDOR_ID  = 3'b001;
    localparam logic [7:0] CTRL0_RST  = 8'h1F;
    localparam logic [7:0] COUNT_RST  = 8'd3;
    localparam int         BYTE_W     = 8;

    typedef enum logic [2:0] {
        S_IDLE,
        S_DEVADDR,
        S_INDEX,
        S_COUNT,
        S_WDATA,
        S_RDACK,
        S_TX
    } smb_state_e;

    typedef struct packed {
        logic [3:0] num;
        logic [2:0] den;
    } ratio_t;

    function automatic ratio_t ratio_decode(input logic [2:0] code);
        ratio_t r;
        case (code)
            3'd0:    r = '{num: 4'd3,  den: 3'd1};
            3'd1:    r = '{num: 4'd4,  den: 3'd1};
            3'd2:    r = '{num: 4'd5,  den: 3'd1};
            3'd3:    r = '{num: 4'd6,  den: 3'd1};
            3'd4:    r = '{num: 4'd8,  den: 3'd1};
            3'd5:    r = '{num: 4'd9,  den: 3'd2};
            3'd6:    r = '{num: 4'd15, den: 3'd2};
            default: r = '{num: 4'd15, den: 3'd4};
        endcase
        return r;
    endfunction

endpackage

// File: rtl/smb_line_filter.sv
module smb_line_filter #(
    parameter int SYNC = 2,
    parameter int TAPS = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic line_in,
    output logic filt
);

    logic [SYNC-1:0] sync_q;
    logic [TAPS-1:0] hist;

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q <= '1;
            hist   <= '1;
            filt   <= 1'b1;
        end else begin
            sync_q <= {sync_q[SYNC-2:0], line_in};
            hist   <= {hist[TAPS-2:0], sync_q[SYNC-1]};
            if (&hist)
                filt <= 1'b1;
            else if (~|hist)
                filt <= 1'b0;
        end
    end

    // R13: a level change needs a full window of agreeing samples
    p_filt_agree_r13: assert property (@(posedge clk) disable iff (rst)
        (filt != $past(filt)) |-> ($past(hist) == {TAPS{filt}}));

endmodule

// File: rtl/smb_proto_fsm.sv
module smb_proto_fsm
    import clkctl_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       scl_f,
    input  logic       sda_f,
    input  logic [1:0] strap,
    input  logic [7:0] rd_data,
    output logic       sda_oe,
    output logic       wr_en,
    output logic [7:0] idx,
    output logic [7:0] wr_data
);

    smb_state_e state;
    logic       scl_q, sda_q;
    logic [3:0] bitcnt;
    logic [7:0] rx_sh, tx_sh;
    logic [7:0] cnt_last, remain;
    logic       sda_low, mack;

    logic start_det, stop_det, scl_rise, scl_fall, addr_hit;

    assign start_det = scl_f && scl_q && sda_q && !sda_f;
    assign stop_det  = scl_f && scl_q && !sda_q && sda_f;
    assign scl_rise  = scl_f && !scl_q;
    assign scl_fall  = !scl_f && scl_q;
    assign addr_hit  = (rx_sh[7:1] == {ADDR_BASE, strap});

    assign sda_oe  = sda_low;
    assign wr_data = rx_sh;
    assign wr_en   = scl_fall && (bitcnt == 4'd8) && (state == S_WDATA)
                     && (remain != 8'd0) && !start_det && !stop_det;

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= S_IDLE;
            scl_q    <= 1'b1;
            sda_q    <= 1'b1;
            bitcnt   <= '0;
            rx_sh    <= '0;
            tx_sh    <= '0;
            idx      <= '0;
            cnt_last <= COUNT_RST;
            remain   <= '0;
            sda_low  <= 1'b0;
            mack     <= 1'b0;
        end else begin
            scl_q <= scl_f;
            sda_q <= sda_f;
            if (stop_det) begin
                state   <= S_IDLE;
                sda_low <= 1'b0;
            end else if (start_det) begin
                state   <= S_DEVADDR;
                sda_low <= 1'b0;
                bitcnt  <= '0;
            end else if (state != S_IDLE) begin
                if (scl_rise) begin
                    if (bitcnt < 4'd8)  rx_sh <= {rx_sh[6:0], sda_f};
                    if (bitcnt == 4'd8) mack  <= ~sda_f;
                    if (bitcnt != 4'd9) bitcnt <= bitcnt + 4'd1;
                end else if (scl_fall) begin
                    if (state == S_TX) begin
                        if (bitcnt >= 4'd1 && bitcnt <= 4'd7) begin
                            tx_sh   <= {tx_sh[6:0], 1'b0};
                            sda_low <= ~tx_sh[6];
                        end else if (bitcnt == 4'd8) begin
                            sda_low <= 1'b0;
                        end else if (bitcnt == 4'd9) begin
                            if (mack) begin
                                tx_sh   <= rd_data;
                                sda_low <= ~rd_data[7];
                                idx     <= idx + 8'd1;
                                bitcnt  <= '0;
                            end else begin
                                state   <= S_IDLE;
                                sda_low <= 1'b0;
                            end
                        end
                    end else if (bitcnt == 4'd8) begin
                        case (state)
                            S_DEVADDR: begin
                                if (addr_hit) begin
                                    sda_low <= 1'b1;
                                    state   <= rx_sh[0] ? S_RDACK : S_INDEX;
                                end else begin
                                    state <= S_IDLE;
                                end
                            end
                            S_INDEX: begin
                                idx     <= rx_sh;
                                sda_low <= 1'b1;
                                state   <= S_COUNT;
                            end
                            S_COUNT: begin
                                cnt_last <= rx_sh;
                                remain   <= rx_sh;
                                sda_low  <= 1'b1;
                                state    <= S_WDATA;
                            end
                            S_WDATA: begin
                                if (remain != 8'd0) begin
                                    idx     <= idx + 8'd1;
                                    remain  <= remain - 8'd1;
                                    sda_low <= 1'b1;
                                end else begin
                                    state <= S_IDLE;
                                end
                            end
                            default: ;
                        endcase
                    end else if (bitcnt == 4'd9) begin
                        bitcnt <= '0;
                        if (state == S_RDACK) begin
                            state   <= S_TX;
                            tx_sh   <= cnt_last;
                            sda_low <= ~cnt_last[7];
                        end else begin
                            sda_low <= 1'b0;
                        end
                    end
                end
            end
        end
    end

    // R11: the line is released whenever the slave is not in a transfer
    p_idle_release_r11: assert property (@(posedge clk) disable iff (rst)
        (state == S_IDLE) |-> !sda_oe);

    // R11: no data-line change while the bus clock is high, outside start/stop
    p_sda_steady_r11: assert property (@(posedge clk) disable iff (rst)
        (scl_f && scl_q && !$past(start_det) && !$past(stop_det)) |-> $stable(sda_oe));

    // R4: every stored data byte consumes one unit of the transfer count
    p_wr_consumes_r4: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> (remain == $past(remain) - 8'd1));

endmodule

// File: rtl/ctl_regfile.sv
module ctl_regfile
    import clkctl_pkg::*;
#(
    parameter logic [4:0] REV_ID = 5'b00001
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       wr_en,
    input  logic [7:0] idx,
    input  logic [7:0] wr_data,
    output logic [7:0] rd_data,
    output logic [7:0] ctrl0,
    output logic       tst1
);

    localparam logic [7:0] ID_BYTE = {REV_ID, VENDOR_ID};

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl0 <= CTRL0_RST;
            tst1  <= 1'b0;
        end else if (wr_en) begin
            if (idx == 8'd0) ctrl0 <= wr_data;
            if (idx == 8'd1) tst1  <= wr_data[0];
        end
    end

    always_comb begin
        case (idx)
            8'd0:    rd_data = ctrl0;
            8'd1:    rd_data = {7'd0, tst1};
            8'd2:    rd_data = ID_BYTE;
            default: rd_data = 8'h00;
        endcase
    end

    // R12: storage only moves on a write strobe
    p_hold_no_write_r12: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> ($stable(ctrl0) && $stable(tst1)));

    // R12: rewriting the held value leaves it untouched
    p_rewrite_same_r12: assert property (@(posedge clk) disable iff (rst)
        (wr_en && idx == 8'd0 && wr_data == ctrl0) |=> $stable(ctrl0));

endmodule

// File: rtl/clkgen_smb_ctrl.sv
module clkgen_smb_ctrl
    import clkctl_pkg::*;
#(
    parameter logic [4:0] REV_ID    = 5'b00001,
    parameter int         NUM_OUT   = 4,
    parameter int         FILT_TAPS = 3
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               scl_in,
    input  logic               sda_in,
    output logic               sda_oe,
    input  logic [1:0]         strap_a,
    input  logic               oe_pin,
    input  logic               bypass_n,
    output logic [NUM_OUT-1:0] out_en,
    output logic [NUM_OUT-1:0] out_hiz,
    output logic               sel_pll,
    output logic [2:0]         mult_code,
    output logic [3:0]         mult_num,
    output logic [2:0]         mult_den,
    output logic [1:0]         vendor_test
);

    logic       scl_f, sda_f;
    logic       wr_en, tst1;
    logic [7:0] idx, wr_data, rd_data, ctrl0;
    ratio_t     ratio;

    smb_line_filter #(.SYNC(2), .TAPS(FILT_TAPS)) u_scl_filt (
        .clk(clk), .rst(rst), .line_in(scl_in), .filt(scl_f));

    smb_line_filter #(.SYNC(2), .TAPS(FILT_TAPS)) u_sda_filt (
        .clk(clk), .rst(rst), .line_in(sda_in), .filt(sda_f));

    smb_proto_fsm u_fsm (
        .clk(clk), .rst(rst), .scl_f(scl_f), .sda_f(sda_f), .strap(strap_a),
        .rd_data(rd_data), .sda_oe(sda_oe), .wr_en(wr_en), .idx(idx),
        .wr_data(wr_data));

    ctl_regfile #(.REV_ID(REV_ID)) u_regs (
        .clk(clk), .rst(rst), .wr_en(wr_en), .idx(idx), .wr_data(wr_data),
        .rd_data(rd_data), .ctrl0(ctrl0), .tst1(tst1));

    assign ratio       = ratio_decode(ctrl0[6:4]);
    assign mult_code   = ctrl0[6:4];
    assign mult_num    = ratio.num;
    assign mult_den    = ratio.den;
    assign vendor_test = {ctrl0[7], tst1};
    assign sel_pll     = bypass_n;

    for (genvar i = 0; i < NUM_OUT; i++) begin : g_out
        assign out_en[i]  = oe_pin & ctrl0[i];
        assign out_hiz[i] = ~(oe_pin & ctrl0[i]);
    end

    // R7: the denominator is a power of two and the ratio never falls below 3
    p_ratio_legal_r7: assert property (@(posedge clk) disable iff (rst)
        $onehot(mult_den) && (mult_num >= 4'd3));

    // R8: no output may switch while the hardware enable is low
    p_oe_gate_r8: assert property (@(posedge clk) disable iff (rst)
        !oe_pin |-> (out_en == '0));

endmodule

// File: tb/clkgen_smb_ctrl_tb.sv
module clkgen_smb_ctrl_tb;

    localparam int Q = 5;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       scl = 1'b1;
    logic       sda_m = 1'b1;
    logic [1:0] strap = 2'b10;
    logic       oe = 1'b1;
    logic       byp_n = 1'b1;
    logic       sda_oe, sel_pll;
    logic [3:0] out_en, out_hiz, mult_num;
    logic [2:0] mult_code, mult_den;
    logic [1:0] vendor_test;
    wire        sda_line = sda_m & ~sda_oe;

    int errors = 0;
    int checks = 0;
    bit glitch_on = 1'b0;
    bit mon_on = 1'b0;
    int mon_changes = 0;
    logic [12:0] mon_prev = '0;

    always #5 clk = ~clk;

    clkgen_smb_ctrl u_dut (
        .clk(clk), .rst(rst), .scl_in(scl), .sda_in(sda_line), .sda_oe(sda_oe),
        .strap_a(strap), .oe_pin(oe), .bypass_n(byp_n), .out_en(out_en),
        .out_hiz(out_hiz), .sel_pll(sel_pll), .mult_code(mult_code),
        .mult_num(mult_num), .mult_den(mult_den), .vendor_test(vendor_test));

    always @(posedge clk) begin
        mon_prev <= {out_en, out_hiz, mult_code, vendor_test};
        if (mon_on && ({out_en, out_hiz, mult_code, vendor_test} != mon_prev))
            mon_changes <= mon_changes + 1;
    end

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #2;
    endtask

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic bus_start();
        sda_m = 1'b1; tick(2*Q);
        scl = 1'b1;   tick(Q);
        sda_m = 1'b0; tick(Q);
        scl = 1'b0;   tick(Q);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; tick(2*Q);
        scl = 1'b1;   tick(Q);
        sda_m = 1'b1; tick(2*Q);
    endtask

    task automatic send_byte(input logic [7:0] b, output bit ack);
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i];
            tick(Q);
            scl = 1'b1;
            if (glitch_on && i == 7 && b[i]) begin
                tick(5); sda_m = 1'b0;
                tick(2); sda_m = 1'b1;
                tick(2*Q-7);
            end else begin
                tick(2*Q);
            end
            scl = 1'b0;
            tick(Q);
        end
        sda_m = 1'b1; tick(Q);
        scl = 1'b1;   tick(Q);
        ack = ~sda_line;
        tick(Q);
        scl = 1'b0;   tick(Q);
    endtask

    task automatic recv_byte(input bit give_ack, output logic [7:0] b);
        sda_m = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            tick(Q);
            scl = 1'b1; tick(Q);
            b[i] = sda_line;
            tick(Q);
            scl = 1'b0; tick(Q);
        end
        sda_m = ~give_ack; tick(Q);
        scl = 1'b1; tick(2*Q);
        scl = 1'b0; tick(Q);
        sda_m = 1'b1;
    endtask

    task automatic blk_write(input logic [7:0] addr, input logic [7:0] index,
                             input logic [7:0] cnt, input int nbytes,
                             input logic [31:0] data, output logic [6:0] acks);
        bit a;
        acks = '0;
        bus_start();
        send_byte(addr, a);  acks[0] = a;
        if (a) begin
            send_byte(index, a); acks[1] = a;
            send_byte(cnt, a);   acks[2] = a;
            for (int k = 0; k < nbytes; k++) begin
                send_byte(data[8*k +: 8], a);
                acks[3+k] = a;
            end
        end
        bus_stop();
        tick(4*Q);
    endtask

    task automatic blk_read(input logic [7:0] wa, input logic [7:0] index, input int n,
                            output logic [7:0] cnt, output logic [23:0] data);
        bit a;
        logic [7:0] b;
        data = '0;
        bus_start();
        send_byte(wa, a);
        send_byte(index, a);
        bus_start();
        send_byte(wa | 8'h01, a);
        recv_byte(1'b1, cnt);
        for (int k = 0; k < n; k++) begin
            recv_byte(k != n - 1, b);
            data[8*k +: 8] = b;
        end
        bus_stop();
        tick(4*Q);
    endtask

    // reg0 value, oe, expected enables, numerator, denominator
    localparam logic [19:0] VEC [8] = '{
        {8'h0F, 1'b1, 4'hF, 4'd3,  3'd1},
        {8'h1A, 1'b1, 4'hA, 4'd4,  3'd1},
        {8'h25, 1'b0, 4'h0, 4'd5,  3'd1},
        {8'h33, 1'b1, 4'h3, 4'd6,  3'd1},
        {8'h4C, 1'b1, 4'hC, 4'd8,  3'd1},
        {8'h51, 1'b1, 4'h1, 4'd9,  3'd2},
        {8'h68, 1'b0, 4'h0, 4'd15, 3'd2},
        {8'hF6, 1'b1, 4'h6, 4'd15, 3'd4}
    };

    localparam logic [7:0] WA = 8'hDC;

    initial begin
        tick(100000);
        errors++;
        checks++;
        $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [6:0]  acks;
        logic [7:0]  cnt;
        logic [23:0] rd;
        tick(5);
        rst = 1'b0;
        tick(10);

        // reset state
        chk("R1 enables", {28'd0, out_en}, 32'hF);
        chk("R1 code", {29'd0, mult_code}, 32'd1);
        chk("R1 ratio", {25'd0, mult_num, mult_den}, {25'd0, 4'd4, 3'd1});
        chk("R1 test bits", {30'd0, vendor_test}, 32'd0);
        chk("R11 sda idle", {31'd0, sda_oe}, 32'd0);
        chk("R9 sel pll", {31'd0, sel_pll}, 32'd1);

        blk_read(WA, 8'd0, 3, cnt, rd);
        chk("R5 reset count", {24'd0, cnt}, 32'd3);
        chk("R1 R6 reset bytes", {8'd0, rd}, {8'd0, 8'h09, 8'h00, 8'h1F});

        // wrong address: strap is 10, so D8 must be ignored
        blk_write(8'hD8, 8'd0, 8'd1, 1, 32'h00, acks);
        chk("R2 foreign addr nack", {31'd0, acks[0]}, 32'd0);
        chk("R2 no change", {28'd0, out_en}, 32'hF);

        // vector table
        for (int v = 0; v < 8; v++) begin
            oe = VEC[v][11];
            blk_write(WA, 8'd0, 8'd1, 1, {24'd0, VEC[v][19:12]}, acks);
            chk("R3 acks", {25'd0, acks}, 32'h0F);
            chk("R7 code", {29'd0, mult_code}, {29'd0, VEC[v][18:16]});
            chk("R7 ratio", {25'd0, mult_num, mult_den}, {25'd0, VEC[v][6:0]});
            chk("R8 enables", {28'd0, out_en}, {28'd0, VEC[v][10:7]});
            chk("R8 hiz", {28'd0, out_hiz}, {28'd0, ~VEC[v][10:7]});
        end
        chk("R3 test bit 7", {30'd0, vendor_test}, 32'd2);

        // two-byte write and read-back
        oe = 1'b1;
        blk_write(WA, 8'd0, 8'd2, 2, 32'h012C, acks);
        chk("R3 two byte acks", {25'd0, acks}, 32'h1F);
        chk("R3 ctrl0 fields", {25'd0, mult_code, out_en}, {25'd0, 3'd2, 4'hC});
        chk("R3 byte1 test bit", {30'd0, vendor_test}, 32'd1);
        blk_read(WA, 8'd0, 2, cnt, rd);
        chk("R5 count follows write", {24'd0, cnt}, 32'd2);
        chk("R5 data", {8'd0, rd}, {16'd0, 8'h01, 8'h2C});

        // overrun past the count
        blk_write(WA, 8'd1, 8'd1, 2, 32'h0100, acks);
        chk("R4 extra byte nack", {25'd0, acks}, 32'h0F);
        blk_read(WA, 8'd1, 1, cnt, rd);
        chk("R4 extra discarded", {24'd0, rd[7:0]}, 32'h00);
        chk("R4 count", {24'd0, cnt}, 32'd1);

        // read-only and nonexistent indices
        blk_write(WA, 8'd2, 8'd2, 2, 32'hBBAA, acks);
        chk("R6 acks", {25'd0, acks}, 32'h1F);
        blk_read(WA, 8'd2, 2, cnt, rd);
        chk("R6 readback", {16'd0, rd[15:0]}, {16'd0, 8'h00, 8'h09});

        // stop in the middle of a write
        blk_write(WA, 8'd0, 8'd3, 1, 32'h3F, acks);
        chk("R10 partial ack", {25'd0, acks}, 32'h0F);
        chk("R10 committed", {25'd0, mult_code, out_en}, {25'd0, 3'd3, 4'hF});
        blk_read(WA, 8'd0, 1, cnt, rd);
        chk("R10 next transfer", {16'd0, cnt, rd[7:0]}, {16'd0, 8'd3, 8'h3F});

        // rewrite same value
        tick(2);
        mon_on = 1'b1;
        blk_write(WA, 8'd0, 8'd1, 1, 32'h3F, acks);
        mon_on = 1'b0;
        chk("R12 ack", {25'd0, acks}, 32'h0F);
        chk("R12 no output change", mon_changes, 0);

        // short SDA glitch during a data bit
        glitch_on = 1'b1;
        blk_write(WA, 8'd0, 8'd1, 1, 32'h9E, acks);
        glitch_on = 1'b0;
        chk("R13 glitch acks", {25'd0, acks}, 32'h0F);
        chk("R13 stored", {25'd0, mult_code, out_en}, {25'd0, 3'd1, 4'hE});

        // hardware enable low
        oe = 1'b0; tick(2);
        chk("R8 oe low", {24'd0, out_en, out_hiz}, {24'd0, 4'h0, 4'hF});
        oe = 1'b1; tick(2);
        chk("R8 oe high", {28'd0, out_en}, 32'hE);

        // bypass pin
        byp_n = 1'b0; tick(2);
        chk("R9 bypass", {31'd0, sel_pll}, 32'd0);
        byp_n = 1'b1; tick(2);
        chk("R9 pll", {31'd0, sel_pll}, 32'd1);
        chk("R11 sda released", {31'd0, sda_oe}, 32'd0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule